// File: doc/BRIEF.md
# Basic-Block Signature Flow Checker

This block observes an instruction trace taken from a processor's debug port and checks that the program follows its expected control flow. It never drives anything back into the processor. Each trace beat carries an executed instruction word and the address it was fetched from. The monitor splits this stream into basic blocks. A basic block is a straight run of instructions that ends at the first branch or jump. While a block runs, the monitor folds every instruction of the block into a 32-bit signature.

When a block closes, three values are compared against a small associative table: the block's first address, its last address and its signature. The table is loaded through a write port while checking is switched off. If no entry matches the first address, or if the stored last address or signature disagrees with what was seen, a control-flow error is raised. The error shows up as a sticky flag and as a one-cycle pulse, and the pulse cycle also presents the first address of the block that failed.

The monitor only detects errors. Recovery, such as reset or rollback, is handled elsewhere, and so is building the table from a program image.

Top module: `bbsig_flow_monitor`

## Requirements
- R1: After reset, `cfe_flag` and `cfe_pulse` are 0 and every table entry is invalid, so the first block checked against an unloaded table reports an error.
- R2: A trace word whose bits [31:28] equal 4'hB is a block terminator. It belongs to the block it closes, and its address is that block's end address. A block may consist of the terminator alone.
- R3: The signature is 32 bits. It is cleared at the start of each block, and each accepted beat updates it as sig = {sig[30:0], sig[31]} ^ word. This covers the first beat of the block and the terminator.
- R4: A block whose start address, end address and signature all equal those of a valid table entry produces no error.
- R5: A block whose start address matches an entry but whose signature differs raises an error.
- R6: A block whose start address matches no valid entry raises an error.
- R7: A block whose start address and signature match an entry but whose end address differs raises an error.
- R8: An error drives `cfe_pulse` high for exactly the cycle after the terminator beat is accepted. In that cycle `cfe_pc` holds the start address of the failing block. A block that passes leaves `cfe_pulse` low.
- R9: `cfe_flag` rises together with `cfe_pulse` and stays high until `clear_err` is sampled high. If a new error is detected in the same cycle as `clear_err`, the flag stays set.
- R10: Table writes are ignored while `enable` is high.
- R11: Trace beats are ignored while `enable` is low. Dropping `enable` discards any partly seen block, so the first valid beat after `enable` returns starts a new block.
- R12: Cycles with `tr_valid` low change neither the signature nor the block state, even if the trace word looks like a terminator.
- R13: If several valid entries share the start address of a block, the entry with the lowest index is used for the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Checking on; table writes blocked |
| clear_err | input | 1 | Clears the sticky error flag |
| tr_valid | input | 1 | Trace beat valid |
| tr_pc | input | 32 | Address of the traced instruction |
| tr_instr | input | 32 | Traced instruction word |
| tw_en | input | 1 | Table write strobe |
| tw_idx | input | 4 | Table entry index to write |
| tw_valid | input | 1 | Valid bit written to the entry |
| tw_start_pc | input | 32 | Block start address written to the entry |
| tw_end_pc | input | 32 | Block end address written to the entry |
| tw_sig | input | 32 | Block signature written to the entry |
| cfe_flag | output | 1 | Sticky control-flow-error flag |
| cfe_pulse | output | 1 | One-cycle error report |
| cfe_pc | output | 32 | Start address of the failing block, valid with `cfe_pulse` |

## Verification
The assertions assume that a clear request and the trace are independent. They also assume that a pulse can only follow an accepted terminator beat, so they expect the trace to arrive one word per cycle with `tr_valid` qualifying it. The stimulus changes every input one time unit after a rising edge. Table writes are made while checking is off, apart from one deliberate write with checking on, which tests that such writes are ignored. Deliberate cases cover each way a block can fail: gaps with a terminator-looking word on an invalid beat, an enable drop in the middle of a block, and a clear that coincides with a new error.

// File: rtl/bbsig_pkg.sv
package bbsig_pkg;

    localparam int PC_W  = 32;
    localparam int SIG_W = 32;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [SIG_W-1:0] sig_t;

    // One reference entry of the signature table
    typedef struct packed {
        logic valid;
        pc_t  start_pc;
        pc_t  end_pc;
        sig_t sig;
    } tbl_entry_t;

    // Block tracking state
    typedef struct packed {
        logic in_blk;
        pc_t  start_pc;
        sig_t sig;
    } trk_state_t;

    // Error reporting state
    typedef struct packed {
        logic flag;
        logic pulse;
        pc_t  pc;
    } flag_state_t;

    // Rotate-left-by-one then fold in the new word
    function automatic sig_t sig_step(sig_t acc, sig_t word);
        return {acc[SIG_W-2:0], acc[SIG_W-1]} ^ word;
    endfunction

endpackage

// File: rtl/bbsig_tracker.sv
module bbsig_tracker
    import bbsig_pkg::*;
#(
    parameter sig_t TERM_MASK  = 32'hF000_0000,
    parameter sig_t TERM_MATCH = 32'hB000_0000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tr_valid,
    input  pc_t  tr_pc,
    input  sig_t tr_instr,
    output logic blk_end,
    output pc_t  blk_start_pc,
    output pc_t  blk_end_pc,
    output sig_t blk_sig
);

    trk_state_t st_d, st_q;
    logic       is_term;
    sig_t       base_sig;
    sig_t       next_sig;
    pc_t        start_pc;

    always_comb begin
        is_term  = (tr_instr & TERM_MASK) == TERM_MATCH;
        base_sig = st_q.in_blk ? st_q.sig : '0;
        start_pc = st_q.in_blk ? st_q.start_pc : tr_pc;
        next_sig = sig_step(base_sig, tr_instr);

        st_d = st_q;
        if (!enable) begin
            // drop any partial block
            st_d.in_blk = 1'b0;
        end else if (tr_valid) begin
            if (is_term) begin
                st_d.in_blk = 1'b0;
                st_d.sig    = '0;
            end else begin
                st_d.in_blk   = 1'b1;
                st_d.start_pc = start_pc;
                st_d.sig      = next_sig;
            end
        end

        blk_end      = enable && tr_valid && is_term;
        blk_start_pc = start_pc;
        blk_end_pc   = tr_pc;
        blk_sig      = next_sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bbsig_table.sv
module bbsig_table
    import bbsig_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tbl_entry_t       wr_entry,
    input  pc_t              lookup_pc,
    output logic             hit,
    output tbl_entry_t       hit_entry
);

    tbl_entry_t [ENTRIES-1:0] ent_d, ent_q;
    logic       [ENTRIES-1:0] match;

    // per-entry associative compare
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_q[g].valid && (ent_q[g].start_pc == lookup_pc);
    end

    always_comb begin
        ent_d = ent_q;
        if (wr_en && (int'(wr_idx) < ENTRIES)) begin
            ent_d[wr_idx] = wr_entry;
        end
    end

    // lowest matching index wins
    always_comb begin
        hit       = |match;
        hit_entry = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_entry = ent_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

endmodule

// File: rtl/bbsig_verdict.sv
module bbsig_verdict
    import bbsig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_err,
    input  logic       blk_end,
    input  pc_t        start_pc,
    input  pc_t        end_pc,
    input  sig_t       blk_sig,
    input  logic       hit,
    input  tbl_entry_t hit_entry,
    output logic       cfe_flag,
    output logic       cfe_pulse,
    output pc_t        cfe_pc
);

    flag_state_t st_d, st_q;
    logic        agree;
    logic        bad;

    always_comb begin
        agree = hit && hit_entry.valid
                && (hit_entry.end_pc == end_pc)
                && (hit_entry.sig == blk_sig);
        bad   = blk_end && !agree;

        st_d       = st_q;
        st_d.pulse = bad;
        if (bad) begin
            st_d.pc = start_pc;
        end
        // a fresh error outranks a clear
        st_d.flag = bad || (st_q.flag && !clear_err);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfe_flag  = st_q.flag;
    assign cfe_pulse = st_q.pulse;
    assign cfe_pc    = st_q.pc;

endmodule

// File: rtl/bbsig_flow_monitor.sv
module bbsig_flow_monitor
    import bbsig_pkg::*;
#(
    parameter int   ENTRIES    = 16,
    parameter sig_t TERM_MASK  = 32'hF000_0000,
    parameter sig_t TERM_MATCH = 32'hB000_0000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       clear_err,
    input  logic                       tr_valid,
    input  logic [PC_W-1:0]            tr_pc,
    input  logic [SIG_W-1:0]           tr_instr,
    input  logic                       tw_en,
    input  logic [$clog2(ENTRIES)-1:0] tw_idx,
    input  logic                       tw_valid,
    input  logic [PC_W-1:0]            tw_start_pc,
    input  logic [PC_W-1:0]            tw_end_pc,
    input  logic [SIG_W-1:0]           tw_sig,
    output logic                       cfe_flag,
    output logic                       cfe_pulse,
    output logic [PC_W-1:0]            cfe_pc
);

    logic       blk_end;
    pc_t        blk_start_pc;
    pc_t        blk_end_pc;
    sig_t       blk_sig;
    logic       hit;
    tbl_entry_t hit_entry;
    tbl_entry_t wr_entry;
    logic       wr_ok;

    assign wr_entry = '{valid: tw_valid, start_pc: tw_start_pc,
                        end_pc: tw_end_pc, sig: tw_sig};
    assign wr_ok    = tw_en && !enable;

    bbsig_tracker #(
        .TERM_MASK (TERM_MASK),
        .TERM_MATCH(TERM_MATCH)
    ) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .tr_valid    (tr_valid),
        .tr_pc       (tr_pc),
        .tr_instr    (tr_instr),
        .blk_end     (blk_end),
        .blk_start_pc(blk_start_pc),
        .blk_end_pc  (blk_end_pc),
        .blk_sig     (blk_sig)
    );

    bbsig_table #(
        .ENTRIES(ENTRIES)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .wr_idx   (tw_idx),
        .wr_entry (wr_entry),
        .lookup_pc(blk_start_pc),
        .hit      (hit),
        .hit_entry(hit_entry)
    );

    bbsig_verdict u_verdict (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_err(clear_err),
        .blk_end  (blk_end),
        .start_pc (blk_start_pc),
        .end_pc   (blk_end_pc),
        .blk_sig  (blk_sig),
        .hit      (hit),
        .hit_entry(hit_entry),
        .cfe_flag (cfe_flag),
        .cfe_pulse(cfe_pulse),
        .cfe_pc   (cfe_pc)
    );

endmodule

// File: rtl/bbsig_flow_monitor_chk.sv
module bbsig_flow_monitor_chk #(
    parameter logic [31:0] TERM_MASK  = 32'hF000_0000,
    parameter logic [31:0] TERM_MATCH = 32'hB000_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic        clear_err,
    input logic        tr_valid,
    input logic [31:0] tr_instr,
    input logic        cfe_flag,
    input logic        cfe_pulse
);

    // R9
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfe_pulse |-> cfe_flag);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfe_flag && !clear_err) |=> cfe_flag);

    // R9
    clear_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_err |=> (cfe_flag == cfe_pulse));

    // R9
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfe_flag) |-> cfe_pulse);

    // R8 R11
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfe_pulse |-> $past(enable && tr_valid && ((tr_instr & TERM_MASK) == TERM_MATCH)));

endmodule

bind bbsig_flow_monitor bbsig_flow_monitor_chk #(
    .TERM_MASK (TERM_MASK),
    .TERM_MATCH(TERM_MATCH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .clear_err(clear_err),
    .tr_valid (tr_valid),
    .tr_instr (tr_instr),
    .cfe_flag (cfe_flag),
    .cfe_pulse(cfe_pulse)
);

// File: tb/bbsig_flow_monitor_tb_top.sv
module bbsig_flow_monitor_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        clear_err = 1'b0;
    logic        tr_valid = 1'b0;
    logic [31:0] tr_pc = '0;
    logic [31:0] tr_instr = '0;
    logic        tw_en = 1'b0;
    logic [3:0]  tw_idx = '0;
    logic        tw_valid = 1'b0;
    logic [31:0] tw_start_pc = '0;
    logic [31:0] tw_end_pc = '0;
    logic [31:0] tw_sig = '0;
    logic        cfe_flag;
    logic        cfe_pulse;
    logic [31:0] cfe_pc;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit mon_on = 1'b0;

    // scoreboard queues (parallel)
    int          q_due[$];
    bit          q_err[$];
    logic [31:0] q_pc[$];
    string       q_req[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    bbsig_flow_monitor dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .clear_err  (clear_err),
        .tr_valid   (tr_valid),
        .tr_pc      (tr_pc),
        .tr_instr   (tr_instr),
        .tw_en      (tw_en),
        .tw_idx     (tw_idx),
        .tw_valid   (tw_valid),
        .tw_start_pc(tw_start_pc),
        .tw_end_pc  (tw_end_pc),
        .tw_sig     (tw_sig),
        .cfe_flag   (cfe_flag),
        .cfe_pulse  (cfe_pulse),
        .cfe_pc     (cfe_pc)
    );

    function automatic logic [31:0] body_w(int seed, int i);
        return {4'(1 + i % 4), 28'(seed * 977 + i * 131 + 5)};
    endfunction

    function automatic logic [31:0] term_w(int seed);
        return {4'hB, 28'(seed * 31 + 7)};
    endfunction

    // expected signature from R3
    function automatic logic [31:0] sig_of(int seed, int n);
        logic [31:0] s = '0;
        for (int i = 0; i < n; i++) s = {s[30:0], s[31]} ^ body_w(seed, i);
        s = {s[30:0], s[31]} ^ term_w(seed);
        return s;
    endfunction

    // monitor: compares design results against the queue
    always @(negedge clk) begin
        if (mon_on) begin
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                int          d;
                bit          e;
                logic [31:0] p;
                string       r;
                d = q_due.pop_front();
                e = q_err.pop_front();
                p = q_pc.pop_front();
                r = q_req.pop_front();
                checks++;
                if (cfe_pulse !== e || (e && cfe_pc !== p)) begin
                    fails++;
                    $display("FAIL %s: pulse=%0b pc=%h expected pulse=%0b pc=%h (due %0d)",
                             r, cfe_pulse, cfe_pc, e, p, d);
                end
            end else if (cfe_pulse !== 1'b0) begin
                checks++;
                fails++;
                $display("FAIL R8: pulse=%0b expected 0 (no block end due)", cfe_pulse);
            end
        end
    end

    task automatic tbl_write(int idx, bit v, logic [31:0] s, logic [31:0] e, logic [31:0] g);
        @(posedge clk); #1;
        tw_en = 1'b1; tw_idx = 4'(idx); tw_valid = v;
        tw_start_pc = s; tw_end_pc = e; tw_sig = g;
        @(posedge clk); #1;
        tw_en = 1'b0;
    endtask

    task automatic set_enable(bit v);
        @(posedge clk); #1;
        enable = v;
    endtask

    task automatic do_clear();
        @(posedge clk); #1;
        clear_err = 1'b1;
        @(posedge clk); #1;
        clear_err = 1'b0;
    endtask

    task automatic check_flag(bit exp, string req);
        @(negedge clk);
        checks++;
        if (cfe_flag !== exp) begin
            fails++;
            $display("FAIL %s: cfe_flag=%0b expected %0b", req, cfe_flag, exp);
        end
    endtask

    // driver: n body words plus terminator; pushes expected verdict
    task automatic run_block(logic [31:0] pc0, int n, int seed, bit exp_err,
                             string req, bit gaps, bit clr_end);
        for (int i = 0; i <= n; i++) begin
            @(posedge clk); #1;
            tr_valid = 1'b1;
            tr_pc    = pc0 + 4 * i;
            tr_instr = (i < n) ? body_w(seed, i) : term_w(seed);
            if (i == n) begin
                clear_err = clr_end;
                q_due.push_back(cyc + 1);
                q_err.push_back(exp_err);
                q_pc.push_back(pc0);
                q_req.push_back(req);
            end else if (gaps) begin
                @(posedge clk); #1;
                tr_valid = 1'b0;
                tr_pc    = 32'hDEAD_0000;
                tr_instr = 32'hB123_4567;
            end
        end
        @(posedge clk); #1;
        tr_valid  = 1'b0;
        clear_err = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (cfe_flag !== 1'b0 || cfe_pulse !== 1'b0) begin
            fails++;
            $display("FAIL R1: flag=%0b pulse=%0b expected 0 0", cfe_flag, cfe_pulse);
        end
        mon_on = 1'b1;

        // R1: empty table, any block errors
        set_enable(1'b1);
        run_block(32'h100, 3, 1, 1'b1, "R1 R6 R8", 1'b0, 1'b0);
        check_flag(1'b1, "R9");
        do_clear();
        check_flag(1'b0, "R9");

        // load table with checking off
        set_enable(1'b0);
        tbl_write(0, 1'b1, 32'h100, 32'h10C, sig_of(1, 3));
        tbl_write(1, 1'b1, 32'h200, 32'h214, sig_of(2, 5));
        tbl_write(2, 1'b1, 32'h300, 32'h308, sig_of(3, 2) ^ 32'h1);
        tbl_write(3, 1'b1, 32'h400, 32'h414, sig_of(4, 4));
        tbl_write(4, 1'b1, 32'h500, 32'h504, sig_of(5, 1));
        tbl_write(5, 1'b1, 32'h500, 32'h504, sig_of(5, 1) ^ 32'h8000_0000);
        tbl_write(6, 1'b1, 32'h700, 32'h700, sig_of(7, 0));
        set_enable(1'b1);

        run_block(32'h100, 3, 1, 1'b0, "R3 R4", 1'b0, 1'b0);
        run_block(32'h700, 0, 7, 1'b0, "R2 R3", 1'b0, 1'b0);
        run_block(32'h200, 5, 2, 1'b0, "R12", 1'b1, 1'b0);
        check_flag(1'b0, "R4");
        run_block(32'h300, 2, 3, 1'b1, "R5 R8", 1'b0, 1'b0);
        run_block(32'h400, 4, 4, 1'b1, "R7 R8", 1'b0, 1'b0);
        do_clear();
        run_block(32'h500, 1, 5, 1'b0, "R13", 1'b0, 1'b0);
        check_flag(1'b0, "R13");
        run_block(32'h600, 2, 6, 1'b1, "R6 R8", 1'b0, 1'b0);
        check_flag(1'b1, "R9");

        // R9: error in same cycle as clear keeps flag set
        run_block(32'h300, 2, 3, 1'b1, "R9", 1'b0, 1'b1);
        check_flag(1'b1, "R9");
        do_clear();
        check_flag(1'b0, "R9");

        // R10: write while enabled is ignored
        tbl_write(0, 1'b1, 32'h100, 32'h10C, 32'h0);
        run_block(32'h100, 3, 1, 1'b0, "R10", 1'b0, 1'b0);

        // R11: beats with enable low are ignored
        set_enable(1'b0);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            tr_valid = 1'b1;
            tr_pc    = 32'h800 + 4 * i;
            tr_instr = (i == 2) ? term_w(9) : body_w(9, i);
        end
        @(posedge clk); #1 tr_valid = 1'b0;
        check_flag(1'b0, "R11");

        // R11: partial block discarded when enable drops
        set_enable(1'b1);
        for (int i = 0; i < 2; i++) begin
            @(posedge clk); #1;
            tr_valid = 1'b1;
            tr_pc    = 32'h900 + 4 * i;
            tr_instr = body_w(11, i);
        end
        @(posedge clk); #1 tr_valid = 1'b0; enable = 1'b0;
        set_enable(1'b1);
        run_block(32'h100, 3, 1, 1'b0, "R11", 1'b0, 1'b0);
        check_flag(1'b0, "R11");

        repeat (3) @(posedge clk);
        summary();
        $finish;
    end

endmodule